// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests for a small 8-bit processor and hands the processor one vector index at a time. There are fourteen sources: four external pins and ten internal set pulses from timers, serial units, the converter and the watchdog. Each source owns one request flag and one enable bit. The flags live in a high and a low 8-bit request register, and the enable bits live in a matching high and low enable register. A global master-enable bit gates every request. A fixed-order encoder picks the most urgent request that is both pending and enabled.

The processor reaches the registers over a simple byte-wide bus. It signals enable-interrupts, disable-interrupts, acknowledge and return-from-interrupt on single-cycle strobes. When an acknowledge is accepted, the master enable clears by itself. If the taken vector belongs to an external pin, that pin's flag also clears. A return-from-interrupt sets the master enable again. Each external pin has its own polarity bit that selects whether a rising or a falling transition sets its flag.

Top module: `vint_ctrl`

## Requirements
- R1: After reset, all five registers read 0, `irq_req` is 0 and `gie_on` is 0.
- R2: The register addresses are 0xEA (enable, sources 0-7), 0xEB (enable, sources 8-13 in bits 5:0), 0xEC (request, sources 0-7), 0xED (request, sources 8-13 in bits 5:0) and 0xEE (edge polarity, bits 3:0). Bit k of a high register belongs to source k, and bit k of a low register belongs to source 8+k. Bits 7:6 of 0xEB and 0xED, and bits 7:4 of 0xEE, read 0 and ignore writes.
- R3: `irq_req` rises only when `gie_on` is 1 and at least one source is both pending and enabled. It appears one cycle after the condition becomes true, and it falls in the same cycle that `gie_on` clears.
- R4: `irq_vec` is the lowest-numbered pending, enabled source. Source numbers 0-3 are pins 0-3, 4 is receive, 5 is transmit, 6 is the serial unit, 7-10 are timers 0-3, 11 is the converter, 12 is the watchdog and 13 is the interval timer.
- R5: On the cycle after `cpu_ack` is accepted (while `irq_req` is 1), `gie_on` and `irq_req` are 0. `cpu_di` clears `gie_on`, while `cpu_ei` and `cpu_reti` set it. A clearing strobe wins over a setting strobe.
- R6: Polarity bit k set to 1 makes a 0-to-1 transition on `ext_pin[k]` set flag k one cycle later. Set to 0, the bit selects 1-to-0 transitions instead. The opposite transition sets nothing.
- R7: Changing a polarity bit while its pin is static does not set that pin's flag.
- R8: Accepting an acknowledge for vector 0-3 clears that flag. Flags 4-13 keep their value through an acknowledge.
- R9: A bus write stores bit values into flags, with 0 clearing and 1 setting. `periph_set[k]` sets flag 4+k on the next cycle. When a set pulse and a clearing write hit the same flag in the same cycle, the flag ends up 1.
- R10: While `irq_req` stays 1, `irq_vec` holds its value, even if a more urgent source becomes pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (0 when not selected) |
| ext_pin | input | 4 | External interrupt pins |
| periph_set | input | 10 | Set pulses for sources 4 to 13 |
| cpu_ei | input | 1 | Enable-interrupts strobe |
| cpu_di | input | 1 | Disable-interrupts strobe |
| cpu_ack | input | 1 | Vector acknowledge strobe |
| cpu_reti | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_vec | output | 4 | Selected vector index |
| gie_on | output | 1 | Master enable state |

## Verification
A flag changes on the clock edge that samples its set pulse, pin transition or bus write. Reads of that flag are combinational, so the bench reads it at the next falling edge. `irq_req` and `irq_vec` take one edge more, so after any flag, enable or `cpu_ei` change the bench waits one extra falling edge before sampling them. The effects of acknowledge and of `cpu_di` are due at the very next edge, and the bench checks them at the falling edge right after the strobe. Priority checks load each flag pattern with the master enable off, then turn it on. This keeps the held vector from latching a half-written pattern. The bench sweeps every pair of sources and every single-enable mask.

// File: rtl/vint_pkg.sv
package vint_pkg;
  localparam int unsigned SRC_N  = 14;
  localparam int unsigned EXT_N  = 4;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned IDX_W  = $clog2(SRC_N);

  typedef enum logic [2:0] {
    RS_NONE,
    RS_EN_HI,
    RS_EN_LO,
    RS_REQ_HI,
    RS_REQ_LO,
    RS_POL
  } reg_sel_e;
endpackage

// File: rtl/vint_rst_sync.sv
module vint_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/vint_edge.sv
module vint_edge #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  input  logic [N-1:0] pol_cur,
  input  logic [N-1:0] pol_nxt,
  output logic [N-1:0] hit
);
  // Pin level normalised to "active" polarity; stored sample uses the
  // polarity that will be in force next cycle.
  logic [N-1:0] prev_q, prev_d;

  for (genvar g = 0; g < N; g++) begin : g_pin
    logic lvl_cur;
    assign lvl_cur   = ~(pin[g] ^ pol_cur[g]);
    assign hit[g]    = lvl_cur & ~prev_q[g];
    assign prev_d[g] = ~(pin[g] ^ pol_nxt[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/vint_flags.sv
module vint_flags #(
  parameter int unsigned N = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_p,
  input  logic [N-1:0] clr_ack,
  input  logic [N-1:0] sw_we,
  input  logic [N-1:0] sw_val,
  output logic [N-1:0] flag
);
  logic [N-1:0] flag_q, flag_d;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_comb begin
      flag_d[g] = flag_q[g];
      if (clr_ack[g]) flag_d[g] = 1'b0;
      if (sw_we[g])   flag_d[g] = sw_val[g];
      if (set_p[g])   flag_d[g] = 1'b1;
    end

    // R9: a set pulse always leaves the flag at 1
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_p[g] |=> flag_q[g]);
    // R9: a bus write without a competing set stores the written bit
    a_r9_sw_store: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_we[g] && !set_p[g]) |=> (flag_q[g] == $past(sw_val[g])));
    // R8: acknowledge clear takes effect when nothing else touches the bit
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_ack[g] && !set_p[g] && !sw_we[g]) |=> !flag_q[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/vint_prio.sv
module vint_prio #(
  parameter int unsigned N = 14,
  parameter int unsigned W = 4
) (
  input  logic [N-1:0] pend,
  output logic         valid,
  output logic [W-1:0] idx
);
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        valid = 1'b1;
        idx   = W'(i);
      end
    end
  end

  always_comb begin
    if (valid) begin
      // R4: pick is pending and nothing more urgent is pending
      a_r4_pick_pending: assert (pend[idx]);
      a_r4_none_higher:  assert ((pend & ((N'(1) << idx) - N'(1))) == '0);
    end
  end
endmodule

// File: rtl/vint_ctrl.sv
module vint_ctrl
  import vint_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter logic [7:0]  EN_HI_ADDR  = 8'hEA,
  parameter logic [7:0]  EN_LO_ADDR  = 8'hEB,
  parameter logic [7:0]  REQ_HI_ADDR = 8'hEC,
  parameter logic [7:0]  REQ_LO_ADDR = 8'hED,
  parameter logic [7:0]  POL_ADDR    = 8'hEE
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_sel,
  input  logic                      bus_wr,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [BYTE_W-1:0]         bus_wdata,
  output logic [BYTE_W-1:0]         bus_rdata,
  input  logic [EXT_N-1:0]          ext_pin,
  input  logic [SRC_N-EXT_N-1:0]    periph_set,
  input  logic                      cpu_ei,
  input  logic                      cpu_di,
  input  logic                      cpu_ack,
  input  logic                      cpu_reti,
  output logic                      irq_req,
  output logic [IDX_W-1:0]          irq_vec,
  output logic                      gie_on
);
  localparam int unsigned LO_W = SRC_N - BYTE_W;

  logic rst_s;
  vint_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s));

  // ---------------- register decode ----------------
  reg_sel_e rsel;
  logic     wr_go;

  always_comb begin
    rsel = RS_NONE;
    if      (bus_addr == ADDR_W'(EN_HI_ADDR))  rsel = RS_EN_HI;
    else if (bus_addr == ADDR_W'(EN_LO_ADDR))  rsel = RS_EN_LO;
    else if (bus_addr == ADDR_W'(REQ_HI_ADDR)) rsel = RS_REQ_HI;
    else if (bus_addr == ADDR_W'(REQ_LO_ADDR)) rsel = RS_REQ_LO;
    else if (bus_addr == ADDR_W'(POL_ADDR))    rsel = RS_POL;
  end

  assign wr_go = bus_sel & bus_wr;

  // ---------------- state ----------------
  logic [SRC_N-1:0] en_q, en_d;
  logic [EXT_N-1:0] pol_q, pol_d;
  logic             gie_q, gie_d;
  logic             hold_q, hold_d;
  logic [IDX_W-1:0] vec_q, vec_d;

  always_comb begin
    en_d = en_q;
    if (wr_go && rsel == RS_EN_HI) en_d[BYTE_W-1:0]     = bus_wdata;
    if (wr_go && rsel == RS_EN_LO) en_d[SRC_N-1:BYTE_W] = bus_wdata[LO_W-1:0];
  end

  assign pol_d = (wr_go && rsel == RS_POL) ? bus_wdata[EXT_N-1:0] : pol_q;

  // ---------------- edge detection ----------------
  logic [EXT_N-1:0] edge_hit;

  vint_edge #(.N(EXT_N)) u_edge (
    .clk(clk), .rst_n(rst_s), .pin(ext_pin),
    .pol_cur(pol_q), .pol_nxt(pol_d), .hit(edge_hit)
  );

  // ---------------- request flags ----------------
  logic             ack_take;
  logic [SRC_N-1:0] set_p, clr_ack, sw_we, sw_val, flag;

  assign ack_take = cpu_ack & hold_q;
  assign set_p    = {periph_set, edge_hit};
  assign sw_we    = {{LO_W{wr_go && rsel == RS_REQ_LO}},
                     {BYTE_W{wr_go && rsel == RS_REQ_HI}}};
  assign sw_val   = {bus_wdata[LO_W-1:0], bus_wdata};

  always_comb begin
    clr_ack = '0;
    if (ack_take && (vec_q < IDX_W'(EXT_N))) clr_ack[vec_q] = 1'b1;
  end

  vint_flags #(.N(SRC_N)) u_flags (
    .clk(clk), .rst_n(rst_s), .set_p(set_p), .clr_ack(clr_ack),
    .sw_we(sw_we), .sw_val(sw_val), .flag(flag)
  );

  // ---------------- master enable ----------------
  always_comb begin
    gie_d = gie_q;
    if (cpu_ei || cpu_reti)     gie_d = 1'b1;
    if (cpu_di || ack_take)     gie_d = 1'b0;
  end

  // ---------------- selection and hold ----------------
  logic [SRC_N-1:0] pend;
  logic             pick_ok;
  logic [IDX_W-1:0] pick_idx;

  assign pend = flag & en_q & {SRC_N{gie_q}};

  vint_prio #(.N(SRC_N), .W(IDX_W)) u_prio (
    .pend(pend), .valid(pick_ok), .idx(pick_idx)
  );

  always_comb begin
    hold_d = hold_q;
    vec_d  = vec_q;
    if (hold_q) begin
      if (ack_take || !pend[vec_q] || !gie_d) hold_d = 1'b0;
    end else begin
      hold_d = pick_ok & gie_d;
      if (pick_ok) vec_d = pick_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      en_q   <= '0;
      pol_q  <= '0;
      gie_q  <= 1'b0;
      hold_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      en_q   <= en_d;
      pol_q  <= pol_d;
      gie_q  <= gie_d;
      hold_q <= hold_d;
      vec_q  <= vec_d;
    end
  end

  // ---------------- read port ----------------
  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      unique case (rsel)
        RS_EN_HI:  bus_rdata = en_q[BYTE_W-1:0];
        RS_EN_LO:  bus_rdata = BYTE_W'(en_q[SRC_N-1:BYTE_W]);
        RS_REQ_HI: bus_rdata = flag[BYTE_W-1:0];
        RS_REQ_LO: bus_rdata = BYTE_W'(flag[SRC_N-1:BYTE_W]);
        RS_POL:    bus_rdata = BYTE_W'(pol_q);
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign irq_req = hold_q;
  assign irq_vec = vec_q;
  assign gie_on  = gie_q;

  // ---------------- assertions ----------------
  // R3: no request to the processor while the master enable is off
  a_r3_req_needs_gie: assert property (@(posedge clk) disable iff (!rst_s)
    irq_req |-> gie_on);
  // R10: a held vector does not move while the request stays up
  a_r10_vec_hold: assert property (@(posedge clk) disable iff (!rst_s)
    (irq_req && !cpu_ack) |=> (!irq_req || irq_vec == $past(irq_vec)));
  // R5: accepted acknowledge drops request and master enable
  a_r5_ack_drops: assert property (@(posedge clk) disable iff (!rst_s)
    (irq_req && cpu_ack) |=> (!irq_req && !gie_on));
  // R5: disable strobe always clears the master enable
  a_r5_di_clears: assert property (@(posedge clk) disable iff (!rst_s)
    cpu_di |=> !gie_on);
  // R5: return strobe sets the master enable when nothing clears it
  a_r5_reti_sets: assert property (@(posedge clk) disable iff (!rst_s)
    (cpu_reti && !cpu_di && !(cpu_ack && irq_req)) |=> gie_on);
endmodule

// File: tb/vint_ctrl_tb_top.sv
module vint_ctrl_tb_top;
  localparam logic [7:0] A_EN_HI = 8'hEA, A_EN_LO = 8'hEB;
  localparam logic [7:0] A_RQ_HI = 8'hEC, A_RQ_LO = 8'hED, A_POL = 8'hEE;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_sel, bus_wr;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic [3:0] ext_pin;
  logic [9:0] periph_set;
  logic       cpu_ei, cpu_di, cpu_ack, cpu_reti;
  logic       irq_req, gie_on;
  logic [3:0] irq_vec;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  vint_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_pin(ext_pin), .periph_set(periph_set), .cpu_ei(cpu_ei),
    .cpu_di(cpu_di), .cpu_ack(cpu_ack), .cpu_reti(cpu_reti),
    .irq_req(irq_req), .irq_vec(irq_vec), .gie_on(gie_on)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  // 0 = ei, 1 = di, 2 = ack, 3 = reti
  task automatic ctl(input int w);
    @(negedge clk);
    cpu_ei = (w == 0); cpu_di = (w == 1); cpu_ack = (w == 2); cpu_reti = (w == 3);
    @(negedge clk);
    cpu_ei = 1'b0; cpu_di = 1'b0; cpu_ack = 1'b0; cpu_reti = 1'b0;
  endtask

  task automatic set_flags(input logic [13:0] p);
    wr(A_RQ_HI, p[7:0]);
    wr(A_RQ_LO, {2'b00, p[13:8]});
  endtask

  task automatic set_en(input logic [13:0] p);
    wr(A_EN_HI, p[7:0]);
    wr(A_EN_LO, {2'b00, p[13:8]});
  endtask

  task automatic get_flags(output logic [13:0] p);
    logic [7:0] h, l;
    rd(A_RQ_HI, h);
    rd(A_RQ_LO, l);
    p = {l[5:0], h};
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0]  d;
    logic [13:0] f;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    ext_pin = '0; periph_set = '0;
    cpu_ei = 1'b0; cpu_di = 1'b0; cpu_ack = 1'b0; cpu_reti = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);

    // R1 reset state
    rd(A_EN_HI, d); chk("R1 en_hi", d, 0);
    rd(A_EN_LO, d); chk("R1 en_lo", d, 0);
    rd(A_RQ_HI, d); chk("R1 req_hi", d, 0);
    rd(A_RQ_LO, d); chk("R1 req_lo", d, 0);
    rd(A_POL, d);   chk("R1 pol", d, 0);
    chk("R1 irq_req", irq_req, 0);
    chk("R1 gie_on", gie_on, 0);

    // R2 register map and unused bits
    wr(A_EN_HI, 8'hA5); rd(A_EN_HI, d); chk("R2 en_hi", d, 8'hA5);
    wr(A_EN_LO, 8'hFF); rd(A_EN_LO, d); chk("R2 en_lo", d, 8'h3F);
    wr(A_RQ_LO, 8'hFF); rd(A_RQ_LO, d); chk("R2 req_lo", d, 8'h3F);
    wr(A_RQ_HI, 8'h5A); rd(A_RQ_HI, d); chk("R2 req_hi", d, 8'h5A);
    wr(A_POL, 8'hFF);   rd(A_POL, d);   chk("R2 pol", d, 8'h0F);
    wr(A_POL, 8'h00);
    set_flags('0); set_en('0);
    get_flags(f); chk("R7 no flag from polarity writes", f, 0);

    // R9 peripheral set pulses, one per source
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); periph_set = 10'd1 << k;
      @(negedge clk); periph_set = '0;
      get_flags(f); chk("R9 periph set", f, 14'd1 << (k + 4));
      set_flags('0);
    end
    // R9 set beats a clearing write
    wr(A_RQ_HI, 8'h10);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_RQ_HI; bus_wdata = 8'h00; periph_set = 10'd1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; periph_set = '0;
    rd(A_RQ_HI, d); chk("R9 set wins", d, 8'h10);
    wr(A_RQ_HI, 8'h00); rd(A_RQ_HI, d); chk("R9 sw clear", d, 8'h00);
    wr(A_RQ_LO, 8'h20); rd(A_RQ_LO, d); chk("R9 sw set", d, 8'h20);
    set_flags('0);

    // R6 external edges, falling polarity (reset default)
    @(negedge clk); ext_pin[0] = 1'b1;
    cyc(1); get_flags(f); chk("R6 rise ignored in falling mode", f, 0);
    ext_pin[0] = 1'b0;
    cyc(1); get_flags(f); chk("R6 falling edge sets INT0", f, 14'h0001);
    set_flags('0);
    // R6 rising polarity
    wr(A_POL, 8'h0F);
    ext_pin[1] = 1'b1;
    cyc(1); get_flags(f); chk("R6 rising edge sets INT1", f, 14'h0002);
    set_flags('0);
    ext_pin[1] = 1'b0;
    cyc(1); get_flags(f); chk("R6 fall ignored in rising mode", f, 0);
    // R7 polarity change on static pin
    wr(A_POL, 8'h0B);
    cyc(2); get_flags(f); chk("R7 polarity change no flag", f, 0);
    wr(A_POL, 8'h0F);
    cyc(2); get_flags(f); chk("R7 polarity restore no flag", f, 0);

    // R3 gating by master enable and by enable bits
    set_en(14'h3FFF); set_flags(14'h0100);
    cyc(2); chk("R3 no irq while gie off", irq_req, 0);
    ctl(0); chk("R5 ei sets gie", gie_on, 1);
    cyc(1); chk("R3 irq with gie", irq_req, 1); chk("R4 vec 8", irq_vec, 8);
    ctl(1); chk("R3 irq drops with di", irq_req, 0); chk("R5 di clears gie", gie_on, 0);
    ctl(0); set_en('0);
    cyc(2); chk("R3 no irq when masked", irq_req, 0);

    // R3/R4 single-enable sweep with all flags pending
    for (int k = 0; k < 14; k++) begin
      ctl(1); set_flags(14'h3FFF); set_en(14'd1 << k); ctl(0);
      cyc(1);
      chk("R3 irq single enable", irq_req, 1);
      chk("R4 vec single enable", irq_vec, k);
    end
    ctl(1); set_en(14'h3FFF);

    // R4 priority over all pairs
    for (int i = 0; i < 14; i++) begin
      for (int j = i; j < 14; j++) begin
        ctl(1);
        set_flags((14'd1 << i) | (14'd1 << j));
        ctl(0);
        cyc(1);
        chk("R4 pair irq", irq_req, 1);
        chk("R4 pair vec", irq_vec, i);
      end
    end

    // R5/R8 acknowledge behaviour
    ctl(1); set_flags(14'h0101); ctl(0);
    cyc(1); chk("R4 vec 0", irq_vec, 0);
    ctl(2);
    chk("R5 ack drops irq", irq_req, 0); chk("R5 ack clears gie", gie_on, 0);
    get_flags(f); chk("R8 ext flag cleared, internal kept", f, 14'h0100);
    ctl(3); chk("R5 reti sets gie", gie_on, 1);
    cyc(1); chk("R4 next vec after return", irq_vec, 8); chk("R3 irq again", irq_req, 1);
    ctl(2); get_flags(f); chk("R8 internal flag survives ack", f, 14'h0100);
    ctl(3);

    // R10 held vector ignores a more urgent arrival
    ctl(1); set_flags(14'h0020); ctl(0);
    cyc(1); chk("R10 first vec", irq_vec, 5);
    wr(A_RQ_HI, 8'h22);
    cyc(2); chk("R10 still requesting", irq_req, 1); chk("R10 vec held", irq_vec, 5);
    ctl(2); ctl(3);
    cyc(1); chk("R10 urgent vec after return", irq_vec, 1);
    ctl(1); cyc(2); chk("R3 irq off after di", irq_req, 0);

    summary();
    $finish;
  end
endmodule